// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is one DMA channel that copies data words between a single peripheral data register and a dual-ported RAM. Each transfer starts when the peripheral request line chosen by the channel pulses, or when software writes a force command. Software sets up the channel through a small register write port. It writes two buffer start addresses, a transfer count that holds N-1 for N transfers per block, and a control word. The control word picks the direction, the addressing mode, the operating mode, the interrupt point and an optional null write.

In ping-pong mode the channel fills or drains buffer A and then buffer B, and keeps alternating between them. A status output shows which buffer is in use, so software can work on the other one. The one-shot modes turn the channel off by themselves when the programmed work is complete. The null-write option is for SPI-style receivers: after each received word is stored, it writes a zero word back to the peripheral to start the next receive.

Top module: `dmach_top`

## Requirements
- R1: After reset `ch_en`, `buf_b`, `irq`, `ram_en`, `per_rd` and `per_wr` are all 0.
- R2: Control register (select 0) bit fields: [0] enable, [1] direction, [3:2] addressing mode, [4] one-shot, [5] ping-pong, [6] half interrupt, [7] null write. With count register (select 4) = C and addressing mode 00, transfer i of a block (i = 0..C) uses RAM address start+i. The C+2-th transfer uses the start address again.
- R3: Addressing mode 01 (and 11) uses the start address for every transfer.
- R4: Addressing mode 10 takes the RAM address from `per_ram_addr`, sampled in the cycle the RAM is accessed.
- R5: `irq` pulses for one cycle once per block. With bit 6 clear, the pulse follows transfer C+1. With bit 6 set, it follows transfer (C+1)/2, rounded down, with a minimum of 1.
- R6: In one-shot single-buffer mode (bits 5:4 = 01), the channel clears `ch_en` after C+1 transfers and then ignores further requests.
- R7: In ping-pong mode (bit 5 set), blocks alternate between start A (select 2) and start B (select 3), starting with A when the channel is enabled. `buf_b` is 1 while B is in use and toggles at each block end.
- R8: In one-shot ping-pong mode (bits 5:4 = 11), the channel clears `ch_en` after one block in A and one block in B.
- R9: A transfer starts on a pulse of `per_req[k]`, where k is the request select written in bits of select 1. Other request lines have no effect. Writing select 1 with bit 15 set forces exactly one transfer.
- R10: With null write set and direction 0, each RAM write is followed in the next cycle by a `per_wr` strobe carrying the data 0.
- R11: Direction 0 moves `per_rdata` into RAM with a `per_rd` strobe. Direction 1 reads RAM (one-cycle read latency) and presents the word on `per_wdata` with `per_wr`, one cycle after the RAM read.
- R12: A request that arrives while a transfer is in progress is held and served right after that transfer. One such request is held.
- R13: While `ch_en` is 0, requests start no transfer. While it is 1, a control write changes only the enable bit, so direction and modes stay fixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 control, 1 trigger, 2 start A, 3 start B, 4 count) |
| cfg_wdata | input | 16 | Register write data |
| per_req | input | NREQ | Peripheral request lines |
| per_rdata | input | DW | Peripheral data register read value |
| per_ram_addr | input | AW | RAM address supplied by the peripheral (indirect mode) |
| per_rd | output | 1 | Peripheral data read strobe |
| per_wr | output | 1 | Peripheral data write strobe |
| per_wdata | output | DW | Peripheral write data |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, valid one cycle after the access |
| ch_en | output | 1 | Channel enable status |
| buf_b | output | 1 | 1 while buffer B is in use |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest case to reach is a request that lands while a transfer is still in progress. The bench pulses the selected request line in two consecutive cycles, so the second pulse arrives while the first transfer is moving data. It then expects two RAM writes to consecutive addresses. The one-shot ping-pong stop also needs a full block in each buffer before `ch_en` falls. The bench reaches it with a count of 0, so each block is one transfer, and it checks that a later request produces no RAM access. Direction locking is exercised by rewriting the control word while a RAM-to-peripheral channel runs, then checking that the next request still produces a peripheral write and no RAM write.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
   localparam int REG_W = 16;

   localparam logic [2:0] SEL_CTRL  = 3'd0;
   localparam logic [2:0] SEL_TRIG  = 3'd1;
   localparam logic [2:0] SEL_BASEA = 3'd2;
   localparam logic [2:0] SEL_BASEB = 3'd3;
   localparam logic [2:0] SEL_COUNT = 3'd4;

   typedef enum logic [1:0] {
      AM_INC  = 2'b00,
      AM_FIX  = 2'b01,
      AM_IND  = 2'b10,
      AM_FIX2 = 2'b11
   } amode_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MOVE = 2'd1,
      ST_DONE = 2'd2
   } xst_t;

   // control bits [7:1] of the control register
   typedef struct packed {
      logic   nullw;
      logic   half;
      logic   pingpong;
      logic   oneshot;
      amode_t amode;
      logic   dir;
   } ctrl_t;
endpackage

// File: rtl/dmach_cfg.sv
module dmach_cfg
   import dmach_pkg::*;
#(
   parameter int AW   = 8,
   parameter int CW   = 8,
   parameter int NREQ = 8,
   localparam int RSW = $clog2(NREQ)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_sel,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic             auto_off,
   output logic             en,
   output ctrl_t            ctl,
   output logic [RSW-1:0]   reqsel,
   output logic [AW-1:0]    start_a,
   output logic [AW-1:0]    start_b,
   output logic [CW-1:0]    count,
   output logic             start_p,
   output logic             force_p
);
   if (AW > REG_W) begin : g_bad_aw
      $error("dmach_cfg: AW exceeds register width");
   end
   if (CW > REG_W) begin : g_bad_cw
      $error("dmach_cfg: CW exceeds register width");
   end
   if (NREQ < 2 || RSW > REG_W - 1) begin : g_bad_nreq
      $error("dmach_cfg: NREQ out of range");
   end

   assign start_p = cfg_we && (cfg_sel == SEL_CTRL) && cfg_wdata[0] && !en;
   assign force_p = cfg_we && (cfg_sel == SEL_TRIG) && cfg_wdata[REG_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en      <= 1'b0;
         ctl     <= '0;
         reqsel  <= '0;
         start_a <= '0;
         start_b <= '0;
         count   <= '0;
      end else begin
         if (cfg_we) begin
            unique case (cfg_sel)
               SEL_CTRL: begin
                  en <= cfg_wdata[0];
                  if (!en) ctl <= ctrl_t'(cfg_wdata[7:1]);
               end
               SEL_TRIG:  reqsel  <= cfg_wdata[RSW-1:0];
               SEL_BASEA: start_a <= cfg_wdata[AW-1:0];
               SEL_BASEB: start_b <= cfg_wdata[AW-1:0];
               SEL_COUNT: count   <= cfg_wdata[CW-1:0];
               default: ;
            endcase
         end
         if (auto_off) en <= 1'b0;
      end
   end
endmodule

// File: rtl/dmach_addr.sv
module dmach_addr
   import dmach_pkg::*;
#(
   parameter int AW = 8,
   parameter int CW = 8
) (
   input  amode_t        amode,
   input  logic          buf_b,
   input  logic [AW-1:0] start_a,
   input  logic [AW-1:0] start_b,
   input  logic [CW-1:0] idx,
   input  logic [AW-1:0] per_ram_addr,
   output logic [AW-1:0] addr
);
   logic [AW-1:0] base;
   logic [AW-1:0] off;

   assign base = buf_b ? start_b : start_a;

   if (CW >= AW) begin : g_trunc
      assign off = idx[AW-1:0];
   end else begin : g_ext
      assign off = {{(AW-CW){1'b0}}, idx};
   end

   always_comb begin
      unique case (amode)
         AM_INC:  addr = base + off;
         AM_IND:  addr = per_ram_addr;
         default: addr = base;
      endcase
   end
endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
   import dmach_pkg::*;
#(
   parameter int CW   = 8,
   parameter int NREQ = 8,
   localparam int RSW = $clog2(NREQ)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  ctrl_t           ctl,
   input  logic [RSW-1:0]  reqsel,
   input  logic [CW-1:0]   count,
   input  logic            start_p,
   input  logic            force_p,
   input  logic [NREQ-1:0] per_req,
   output logic            mv,
   output logic            dn,
   output logic [CW-1:0]   idx,
   output logic            buf_b,
   output logic            irq,
   output logic            auto_off
);
   xst_t        st;
   logic        pend;
   logic        trig;
   logic        go;
   logic        last;
   logic        blk_end;
   logic        hit_half;
   logic [CW:0] cnt1;
   logic [CW:0] hthr;
   logic [CW:0] hsel;
   logic [CW:0] idx1;

   assign mv   = (st == ST_MOVE);
   assign dn   = (st == ST_DONE);
   assign trig = en && (per_req[reqsel] || force_p);
   assign last = (idx == count);

   assign cnt1     = {1'b0, count} + {{CW{1'b0}}, 1'b1};
   assign hthr     = cnt1 >> 1;
   assign hsel     = (hthr == '0) ? {{CW{1'b0}}, 1'b1} : hthr;
   assign idx1     = {1'b0, idx} + {{CW{1'b0}}, 1'b1};
   assign hit_half = (idx1 == hsel);

   assign blk_end  = dn && last;
   assign auto_off = blk_end && ctl.oneshot && (!ctl.pingpong || buf_b);
   assign go       = en && !auto_off && (trig || pend) && (st != ST_MOVE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         pend  <= 1'b0;
         idx   <= '0;
         buf_b <= 1'b0;
         irq   <= 1'b0;
      end else begin
         irq <= dn && (ctl.half ? hit_half : last);

         if (go)                st <= ST_MOVE;
         else if (st == ST_MOVE) st <= ST_DONE;
         else                   st <= ST_IDLE;

         if (!en || start_p)     pend <= 1'b0;
         else if (go)           pend <= pend && trig;
         else if (trig)         pend <= 1'b1;

         if (start_p) begin
            idx   <= '0;
            buf_b <= 1'b0;
         end else if (dn) begin
            if (last) begin
               idx <= '0;
               if (ctl.pingpong) buf_b <= !buf_b;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dmach_top.sv
module dmach_top
   import dmach_pkg::*;
#(
   parameter int AW   = 8,
   parameter int DW   = 16,
   parameter int CW   = 8,
   parameter int NREQ = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_sel,
   input  logic [15:0]      cfg_wdata,
   input  logic [NREQ-1:0]  per_req,
   input  logic [DW-1:0]    per_rdata,
   input  logic [AW-1:0]    per_ram_addr,
   output logic             per_rd,
   output logic             per_wr,
   output logic [DW-1:0]    per_wdata,
   output logic             ram_en,
   output logic             ram_we,
   output logic [AW-1:0]    ram_addr,
   output logic [DW-1:0]    ram_wdata,
   input  logic [DW-1:0]    ram_rdata,
   output logic             ch_en,
   output logic             buf_b,
   output logic             irq
);
   localparam int RSW = $clog2(NREQ);

   logic           en;
   ctrl_t          ctl;
   logic [RSW-1:0] reqsel;
   logic [AW-1:0]  start_a;
   logic [AW-1:0]  start_b;
   logic [CW-1:0]  count;
   logic           start_p;
   logic           force_p;
   logic           auto_off;
   logic           mv;
   logic           dn;
   logic [CW-1:0]  idx;
   logic           dir_w;

   dmach_cfg #(.AW(AW), .CW(CW), .NREQ(NREQ)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .auto_off(auto_off), .en(en), .ctl(ctl),
      .reqsel(reqsel), .start_a(start_a), .start_b(start_b), .count(count),
      .start_p(start_p), .force_p(force_p)
   );

   dmach_seq #(.CW(CW), .NREQ(NREQ)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(en), .ctl(ctl), .reqsel(reqsel),
      .count(count), .start_p(start_p), .force_p(force_p), .per_req(per_req),
      .mv(mv), .dn(dn), .idx(idx), .buf_b(buf_b), .irq(irq),
      .auto_off(auto_off)
   );

   dmach_addr #(.AW(AW), .CW(CW)) u_addr (
      .amode(ctl.amode), .buf_b(buf_b), .start_a(start_a), .start_b(start_b),
      .idx(idx), .per_ram_addr(per_ram_addr), .addr(ram_addr)
   );

   assign dir_w     = ctl.dir;
   assign ch_en     = en;
   assign ram_en    = mv;
   assign ram_we    = mv && !dir_w;
   assign ram_wdata = per_rdata;
   assign per_rd    = mv && !dir_w;
   assign per_wr    = dn && (dir_w || ctl.nullw);
   assign per_wdata = dir_w ? ram_rdata : '0;
endmodule

// File: rtl/dmach_chk.sv
module dmach_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ch_en,
   input logic          ram_en,
   input logic          ram_we,
   input logic          per_wr,
   input logic [DW-1:0] per_wdata,
   input logic          irq,
   input logic          dir
);
   // R13: no RAM access can start unless the channel was on a cycle earlier
   a_r13_off_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ch_en) |-> !ram_en);

   // R13: direction is frozen while the channel stays enabled
   a_r13_dir_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en && $past(ch_en)) |-> $stable(dir));

   // R11: a RAM write and a peripheral write never share a cycle
   a_r11_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_en && ram_we) |-> !per_wr);

   // R12: each transfer holds the RAM for a single cycle
   a_r12_ram_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      ram_en |=> !ram_en);

   // R5: interrupt is a single-cycle pulse
   a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R10: peripheral writes in the inbound direction carry zero
   a_r10_null_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (per_wr && !dir) |-> (per_wdata == '0));
endmodule

bind dmach_top dmach_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ram_en(ram_en), .ram_we(ram_we),
   .per_wr(per_wr), .per_wdata(per_wdata), .irq(irq), .dir(dir_w)
);

// File: tb/dmach_top_test.sv
module dmach_top_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int NREQ = 8;
   localparam int RQ = 2;

   typedef struct {
      logic          kind;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      string         tag;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [2:0]      cfg_sel = '0;
   logic [15:0]     cfg_wdata = '0;
   logic [NREQ-1:0] per_req = '0;
   logic [DW-1:0]   per_rdata = '0;
   logic [AW-1:0]   per_ram_addr = '0;
   logic            per_rd, per_wr, ram_en, ram_we, ch_en, buf_b, irq;
   logic [DW-1:0]   per_wdata, ram_wdata, ram_rdata;
   logic [AW-1:0]   ram_addr;
   logic [DW-1:0]   mem [0:(1<<AW)-1];
   logic [DW-1:0]   rdq;

   int   checks = 0;
   int   errors = 0;
   int   ev_cnt = 0;
   int   irq_cnt = 0;
   bit   done = 1'b0;
   exp_t sbq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dmach_top #(.AW(AW), .DW(DW), .CW(8), .NREQ(NREQ)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .per_req(per_req), .per_rdata(per_rdata),
      .per_ram_addr(per_ram_addr), .per_rd(per_rd), .per_wr(per_wr),
      .per_wdata(per_wdata), .ram_en(ram_en), .ram_we(ram_we),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .ch_en(ch_en), .buf_b(buf_b), .irq(irq)
   );

   // dual-ported RAM model, one-cycle read latency
   always_ff @(posedge clk) begin
      if (ram_en && ram_we) mem[ram_addr] <= ram_wdata;
      if (ram_en) rdq <= mem[ram_addr];
   end
   assign ram_rdata = rdq;

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic match(logic k, logic [AW-1:0] a, logic [DW-1:0] d);
      exp_t e;
      ev_cnt++;
      checks++;
      if (sbq.size() == 0) begin
         errors++;
         $display("FAIL R13 unexpected: actual kind %0d addr %h data %h expected none", k, a, d);
      end else begin
         e = sbq.pop_front();
         if (e.kind !== k || e.addr !== a || e.data !== d) begin
            errors++;
            $display("FAIL %s: actual kind %0d addr %h data %h expected kind %0d addr %h data %h",
                     e.tag, k, a, d, e.kind, e.addr, e.data);
         end
      end
   endtask

   // monitor: compare every produced transfer against the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (ram_en && ram_we) match(1'b0, ram_addr, ram_wdata);
         if (per_wr) match(1'b1, '0, per_wdata);
         if (irq) irq_cnt++;
      end
   end

   task automatic push(logic k, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
      exp_t e;
      e.kind = k; e.addr = a; e.data = d; e.tag = tag;
      sbq.push_back(e);
   endtask

   task automatic cfg_wr(logic [2:0] s, logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic setup(logic [7:0] a, logic [7:0] b, logic [7:0] c, logic [15:0] ctrl);
      cfg_wr(3'd0, 16'h0000);
      cfg_wr(3'd2, {8'h0, a});
      cfg_wr(3'd3, {8'h0, b});
      cfg_wr(3'd4, {8'h0, c});
      cfg_wr(3'd1, RQ);
      cfg_wr(3'd0, ctrl);
      irq_cnt = 0;
   endtask

   task automatic pulse(int line);
      @(negedge clk);
      per_req[line] = 1'b1;
      @(negedge clk);
      per_req = '0;
      repeat (3) @(negedge clk);
   endtask

   task automatic xin(logic [DW-1:0] d, logic [AW-1:0] a, string tag);
      per_rdata = d;
      push(1'b0, a, d, tag);
      pulse(RQ);
   endtask

   task automatic sb_empty(string tag);
      chk(sbq.size() == 0, tag, sbq.size(), 0);
   endtask

   initial begin
      int ev0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(ch_en == 0 && buf_b == 0 && irq == 0, "R1 status", {ch_en, buf_b, irq}, 0);
      chk(ram_en == 0 && per_rd == 0 && per_wr == 0, "R1 strobes", {ram_en, per_rd, per_wr}, 0);

      // R2 post-increment with wrap, R5 full-block interrupt
      setup(8'h10, 8'h00, 8'd3, 16'h0001);
      for (int i = 0; i < 5; i++) xin(16'h1000 + 16'(i), 8'h10 + 8'(i % 4), "R2 post-inc");
      sb_empty("R2 all seen");
      chk(irq_cnt == 1, "R5 full irq", irq_cnt, 1);

      // R9 unselected line ignored, force does one transfer
      ev0 = ev_cnt;
      pulse(5);
      chk(ev_cnt == ev0, "R9 other line", ev_cnt - ev0, 0);
      per_rdata = 16'h2222;
      push(1'b0, 8'h11, 16'h2222, "R9 force");
      cfg_wr(3'd1, 16'h8000 | RQ);
      repeat (3) @(negedge clk);
      chk(ev_cnt == ev0 + 1, "R9 force count", ev_cnt - ev0, 1);

      // R3 fixed address
      setup(8'h30, 8'h00, 8'd2, 16'h0005);
      for (int i = 0; i < 3; i++) xin(16'h3000 + 16'(i), 8'h30, "R3 fixed");

      // R4 indirect address
      setup(8'h00, 8'h00, 8'd3, 16'h0009);
      per_ram_addr = 8'h77;
      xin(16'h4444, 8'h77, "R4 indirect");
      per_ram_addr = 8'h55;
      xin(16'h4545, 8'h55, "R4 indirect");

      // R5 half interrupt, count 3 -> after 2nd transfer only
      setup(8'h60, 8'h00, 8'd3, 16'h0041);
      xin(16'h6000, 8'h60, "R5 half");
      chk(irq_cnt == 0, "R5 half early", irq_cnt, 0);
      xin(16'h6001, 8'h61, "R5 half");
      chk(irq_cnt == 1, "R5 half point", irq_cnt, 1);
      xin(16'h6002, 8'h62, "R5 half");
      xin(16'h6003, 8'h63, "R5 half");
      chk(irq_cnt == 1, "R5 half no full", irq_cnt, 1);
      // R5 count 0 with half: minimum one, each transfer
      setup(8'h68, 8'h00, 8'd0, 16'h0041);
      xin(16'h6800, 8'h68, "R5 half min");
      xin(16'h6801, 8'h68, "R5 half min");
      chk(irq_cnt == 2, "R5 half min", irq_cnt, 2);

      // R6 one-shot single buffer
      setup(8'h80, 8'h00, 8'd1, 16'h0011);
      xin(16'h8000, 8'h80, "R6 oneshot");
      chk(ch_en == 1, "R6 still on", ch_en, 1);
      xin(16'h8001, 8'h81, "R6 oneshot");
      chk(ch_en == 0, "R6 self off", ch_en, 0);
      ev0 = ev_cnt;
      pulse(RQ);
      chk(ev_cnt == ev0, "R6 ignored after", ev_cnt - ev0, 0);

      // R7 continuous ping-pong
      setup(8'h20, 8'h40, 8'd1, 16'h0021);
      chk(buf_b == 0, "R7 starts A", buf_b, 0);
      xin(16'h7000, 8'h20, "R7 pingpong");
      xin(16'h7001, 8'h21, "R7 pingpong");
      chk(buf_b == 1, "R7 now B", buf_b, 1);
      xin(16'h7002, 8'h40, "R7 pingpong");
      xin(16'h7003, 8'h41, "R7 pingpong");
      chk(buf_b == 0, "R7 back A", buf_b, 0);
      xin(16'h7004, 8'h20, "R7 pingpong");
      chk(irq_cnt == 2 && ch_en == 1, "R7 irq per block", irq_cnt, 2);

      // R8 one-shot ping-pong
      setup(8'h90, 8'hA0, 8'd0, 16'h0031);
      xin(16'h9000, 8'h90, "R8 oneshot pp");
      chk(ch_en == 1 && buf_b == 1, "R8 after A", {ch_en, buf_b}, 3);
      xin(16'h9001, 8'hA0, "R8 oneshot pp");
      chk(ch_en == 0, "R8 self off", ch_en, 0);
      ev0 = ev_cnt;
      pulse(RQ);
      chk(ev_cnt == ev0, "R8 ignored after", ev_cnt - ev0, 0);

      // R10 null write
      setup(8'hB0, 8'h00, 8'd0, 16'h0081);
      push(1'b0, 8'hB0, 16'hB00B, "R10 null ram");
      push(1'b1, 8'h00, 16'h0000, "R10 null per");
      per_rdata = 16'hB00B;
      pulse(RQ);
      sb_empty("R10 both seen");

      // R11 RAM to peripheral, reading words stored by the R2 test
      setup(8'h12, 8'h00, 8'd1, 16'h0003);
      push(1'b1, 8'h00, 16'h1002, "R11 ram2per");
      pulse(RQ);
      push(1'b1, 8'h00, 16'h1003, "R11 ram2per");
      pulse(RQ);
      // R13 control rewrite while enabled keeps direction
      cfg_wr(3'd0, 16'h0001);
      push(1'b1, 8'h00, 16'h1002, "R13 dir locked");
      pulse(RQ);
      chk(ch_en == 1, "R13 still on", ch_en, 1);

      // R12 back-to-back requests
      setup(8'hC0, 8'h00, 8'd3, 16'h0001);
      per_rdata = 16'h5151;
      push(1'b0, 8'hC0, 16'h5151, "R12 pending");
      push(1'b0, 8'hC1, 16'h5151, "R12 pending");
      ev0 = ev_cnt;
      @(negedge clk);
      per_req[RQ] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      per_req = '0;
      repeat (6) @(negedge clk);
      chk(ev_cnt == ev0 + 2, "R12 both served", ev_cnt - ev0, 2);

      // R13 disabled channel ignores requests
      cfg_wr(3'd0, 16'h0000);
      ev0 = ev_cnt;
      pulse(RQ);
      chk(ev_cnt == ev0 && ch_en == 0, "R13 off ignores", ev_cnt - ev0, 0);

      sb_empty("R2 scoreboard drained");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule